// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received frame, whether the frame should be kept. It looks only at the 48-bit destination address at the head of the frame. The address arrives one byte per valid cycle, first byte first. After the sixth byte the block gives a single verdict. An address equal to the programmed station address is kept. The all-ones broadcast address is kept unless a mode bit blocks it. Group (multicast) addresses are kept when their bin is set in a 64-bin hash table. A promiscuous bit keeps every frame.

A simple write port loads the configuration registers: a mode register, two station address words and one hash word per 32 bins. The hash bin comes from a CRC-32 that is accumulated one byte at a time while the address streams in. The verdict is therefore ready one cycle after the last address byte, with no extra pass over the address.

The sequencer has three states. ST_IDLE waits for the first frame start after reset. ST_ADDR collects address bytes. ST_HOLD ignores input once a verdict has been given. The transitions are:
- ST_IDLE to ST_ADDR on frame start.
- ST_ADDR to ST_ADDR on frame start, which restarts collection.
- ST_ADDR to ST_HOLD when the sixth byte is taken.
- ST_HOLD to ST_ADDR on frame start.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `match_done` and `match_accept` are 0, and every configuration register is 0.
- R2: `match_done` is high for exactly one cycle. That cycle is the one after the clock edge that takes the sixth address byte with `rx_valid` high. Idle cycles between bytes are not counted.
- R3: A frame whose first byte has bit 0 clear is accepted only when all six bytes equal the station address. A mismatch in any byte rejects it.
- R4: The all-ones address is accepted when mode bit 3 is 0 and rejected when mode bit 3 is 1.
- R5: A multicast address has bit 0 of its first byte set and is not all ones. Its hash index is formed as follows:
  - The CRC register starts at all ones.
  - Each byte is fed least significant bit first.
  - The feedback uses polynomial 0x04C11DB7, shifting toward bit 31.
  - There is no final inversion, and the index is CRC bits 31:26.
  - Index bit 5 picks hash word 1 (register address 4) when set and hash word 0 (address 3) when clear. Index bits 4:0 pick the bit within that word.
  - The frame is accepted exactly when that bit is 1.
- R6: With both hash words all ones, every multicast address is accepted.
- R7: When mode bit 5 is 1, every frame is accepted, whatever its address and the other settings.
- R8: A frame start pulse restarts collection, and bytes already taken for the frame are discarded. A byte presented in the same cycle as frame start is dropped. Bytes that arrive before the first frame start, or after the sixth byte and before the next frame start, produce no `match_done`.
- R9: The register addresses are:
  - 0: mode.
  - 1: station low word, holding address bytes 2, 3, 4, 5 in bits 31:24, 23:16, 15:8, 7:0.
  - 2: station high word, holding byte 0 in bits 15:8 and byte 1 in bits 7:0.
  - 3: hash word 0.
  - 4: hash word 1.
  
  Byte 0 is the first byte received. Mode bits other than 5 and 3 have no effect.
- R10: `match_accept` holds the latest verdict until the next frame start pulse. That pulse clears it to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address (CFG_AW) |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| rx_valid | input | 1 | `rx_byte` carries an address byte this cycle |
| rx_byte | input | 8 | Received byte |
| match_done | output | 1 | One-cycle verdict strobe |
| match_accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
The bench builds the filter with the default IDX_W of 6. This gives 64 bins spread across two hash words, so index bit 5 really switches between registers 3 and 4, and every bin can be reached by random multicast addresses. Directed frames place a single bin in each word, exercise broadcast blocking and the unused mode bits, and test restart and stray-byte handling. Random frames mix station hits, broadcasts, multicasts and unicast misses under random modes and tables, with random idle gaps between bytes.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;
    localparam int CRC_W     = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam int PROMISC_BIT = 5;
    localparam int NOBCAST_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_UNICAST,
        CLS_MULTICAST,
        CLS_BROADCAST
    } addr_class_e;

    // One byte of CRC, data bits taken least significant first,
    // register shifting toward its top bit.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] c_in,
        input logic [7:0]       d_in
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[CRC_W-1] ^ d_in[b];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/daf_regs.sv
module daf_regs
    import daf_pkg::*;
#(
    parameter  int IDX_W      = 6,
    localparam int HASH_BINS  = 1 << IDX_W,
    localparam int HASH_WORDS = HASH_BINS / 32,
    localparam int CFG_AW     = $clog2(3 + HASH_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic                 promisc,
    output logic                 nobcast,
    output logic [MAC_W-1:0]     station,
    output logic [HASH_BINS-1:0] hash_vec
);

    logic        promisc_q;
    logic        nobcast_q;
    logic [31:0] sta_lo_q;
    logic [15:0] sta_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            promisc_q <= 1'b0;
            nobcast_q <= 1'b0;
            sta_lo_q  <= '0;
            sta_hi_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(0)) begin
                promisc_q <= cfg_wdata[PROMISC_BIT];
                nobcast_q <= cfg_wdata[NOBCAST_BIT];
            end
            if (cfg_addr == CFG_AW'(1)) sta_lo_q <= cfg_wdata;
            if (cfg_addr == CFG_AW'(2)) sta_hi_q <= cfg_wdata[15:0];
        end
    end

    for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(3 + w))
                word_q <= cfg_wdata;
        end
        assign hash_vec[w*32 +: 32] = word_q;
    end

    assign promisc = promisc_q;
    assign nobcast = nobcast_q;
    assign station = {sta_hi_q, sta_lo_q};

    // R9: a mode write lands in the two live mode bits
    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(0)) |=>
            (promisc == $past(cfg_wdata[PROMISC_BIT]) &&
             nobcast == $past(cfg_wdata[NOBCAST_BIT])));

endmodule

// File: rtl/daf_crc.sv
module daf_crc
    import daf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [7:0]       data,
    output logic [IDX_W-1:0] idx_next
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    always_comb crc_nxt = crc_step_byte(crc_q, data);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc_q <= '1;
        else if (en)
            crc_q <= crc_nxt;
    end

    assign idx_next = crc_nxt[CRC_W-1 -: IDX_W];

    // R5: every frame starts its CRC from all ones
    a_r5_crc_seed: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '1));

    // R5: the CRC only moves when a byte is taken
    a_r5_crc_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc_q));

endmodule

// File: rtl/daf_seq.sv
module daf_seq
    import daf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic rx_valid,
    output logic take,
    output logic last
);

    localparam int CNT_W = $clog2(MAC_BYTES + 1);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_start) state_d = ST_ADDR;
            ST_ADDR: begin
                if (frame_start) state_d = ST_ADDR;
                else if (last)   state_d = ST_HOLD;
            end
            ST_HOLD: if (frame_start) state_d = ST_ADDR;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take = 1'b0;
        last = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                take = rx_valid && !frame_start;
                last = take && (cnt_q == CNT_W'(MAC_BYTES - 1));
            end
            default: begin
                take = 1'b0;
                last = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)
            cnt_q <= '0;
        else if (last)
            cnt_q <= '0;
        else if (take)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: byte counter never passes the address length
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAC_BYTES));

    // R8: frame start always lands in collection at byte zero
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == ST_ADDR && cnt_q == '0));

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter  int IDX_W      = 6,
    localparam int HASH_BINS  = 1 << IDX_W,
    localparam int HASH_WORDS = HASH_BINS / 32,
    localparam int CFG_AW     = $clog2(3 + HASH_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              frame_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              match_done,
    output logic              match_accept
);

    logic                 take;
    logic                 last;
    logic                 promisc;
    logic                 nobcast;
    logic [MAC_W-1:0]     station;
    logic [HASH_BINS-1:0] hash_vec;
    logic [IDX_W-1:0]     hidx;
    logic [MAC_W-9:0]     lead_q;
    logic [MAC_W-1:0]     dest;
    addr_class_e          cls;
    logic                 verdict;
    logic                 done_q;
    logic                 accept_q;

    daf_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .rx_valid    (rx_valid),
        .take        (take),
        .last        (last)
    );

    daf_crc #(.IDX_W(IDX_W)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (frame_start),
        .en       (take),
        .data     (rx_byte),
        .idx_next (hidx)
    );

    daf_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .promisc   (promisc),
        .nobcast   (nobcast),
        .station   (station),
        .hash_vec  (hash_vec)
    );

    // first five bytes, oldest in the top byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            lead_q <= '0;
        else if (take)
            lead_q <= {lead_q[MAC_W-17:0], rx_byte};
    end

    assign dest = {lead_q, rx_byte};

    always_comb begin
        if (&dest)
            cls = CLS_BROADCAST;
        else if (dest[MAC_W-8])
            cls = CLS_MULTICAST;
        else
            cls = CLS_UNICAST;
    end

    always_comb begin
        verdict = 1'b0;
        unique case (cls)
            CLS_BROADCAST: verdict = !nobcast;
            CLS_MULTICAST: verdict = hash_vec[hidx];
            CLS_UNICAST:   verdict = (dest == station);
            default:       verdict = 1'b0;
        endcase
        if (promisc) verdict = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            done_q <= last;
            if (frame_start)
                accept_q <= 1'b0;
            else if (last)
                accept_q <= verdict;
        end
    end

    assign match_done   = done_q;
    assign match_accept = accept_q;

    // R2: the verdict strobe lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |=> !match_done);

    // R7: promiscuous mode keeps the frame
    a_r7_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        (last && promisc) |=> match_accept);

    // R4: blocked broadcast is refused
    a_r4_bcast_block: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !promisc && nobcast && (&dest)) |=> !match_accept);

    // R10: accept only rises together with a verdict strobe
    a_r10_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_accept) |-> match_done);

    // R10: frame start clears the held verdict
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !match_accept);

endmodule

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        match_done;
    logic        match_accept;

    int checks = 0;
    int fails  = 0;
    int ndone  = 0;
    bit acc_seen = 1'b0;
    bit done_at_last = 1'b0;

    logic [31:0] m_mode = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_hi = '0;
    logic [63:0] m_hash = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_addr_filter #(.IDX_W(IDX_W)) dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .frame_start (frame_start), .rx_valid (rx_valid),
        .rx_byte (rx_byte), .match_done (match_done), .match_accept (match_accept)
    );

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reflected CRC, then bit reversal gives the index
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] r;
        logic [31:0] rev;
        r = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            r = r ^ {24'h0, a[47-8*i -: 8]};
            for (int k = 0; k < 8; k++)
                r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        for (int k = 0; k < 32; k++) rev[k] = r[31-k];
        return rev[31:26];
    endfunction

    function automatic bit ref_accept(input logic [47:0] a);
        if (m_mode[5]) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return !m_mode[3];
        if (a[40]) return m_hash[ref_idx(a)];
        return a == {m_hi[15:0], m_lo};
    endfunction

    task automatic tick();
        @(negedge clk);
        if (match_done) begin
            ndone++;
            acc_seen = match_accept;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
        case (a)
            3'd0: m_mode = d;
            3'd1: m_lo = d;
            3'd2: m_hi = d;
            3'd3: m_hash[31:0] = d;
            3'd4: m_hash[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic send_bytes(input logic [47:0] a, input int n, input int gap_max);
        for (int i = 0; i < n; i++) begin
            int g = (gap_max > 0) ? $urandom_range(0, gap_max) : 0;
            repeat (g) begin
                rx_valid = 1'b0; rx_byte = 8'($urandom);
                tick();
            end
            rx_valid = 1'b1; rx_byte = a[47-8*i -: 8];
            tick();
            if (i == 5) done_at_last = match_done;
        end
        rx_valid = 1'b0;
    endtask

    task automatic start_pulse();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic frame(input logic [47:0] a, input int gap_max);
        ndone = 0; done_at_last = 1'b0;
        start_pulse();
        send_bytes(a, 6, gap_max);
        tick();
        tick();
    endtask

    task automatic frame_check(input logic [47:0] a, input int gap_max, input string req);
        bit e;
        e = ref_accept(a);
        frame(a, gap_max);
        check(ndone == 1 && done_at_last, {req, " done"}, ndone, 1);
        check(acc_seen == e, req, int'(acc_seen), int'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report_end();
    end

    initial begin
        logic [47:0] sta;
        logic [47:0] mc;
        logic [5:0]  ix;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check(match_done == 1'b0, "R1 done after reset", int'(match_done), 0);
        check(match_accept == 1'b0, "R1 accept after reset", int'(match_accept), 0);
        // R1: zero registers -> unicast to 0 matches zero station, broadcast allowed
        frame_check(48'h0, 0, "R1 zero station");
        frame_check(48'hFFFF_FFFF_FFFF, 0, "R4 broadcast open after reset");

        // R9/R3: station layout
        sta = 48'h02_1A_2B_3C_4D_5E;
        wr(3'd1, 32'h2B3C4D5E);
        wr(3'd2, 32'hABCD_021A);
        frame_check(sta, 0, "R3 exact station hit");
        frame_check(sta, 3, "R2 station hit with gaps");
        frame_check(sta ^ 48'h00_00_00_00_00_01, 0, "R3 last byte miss");
        frame_check(sta ^ 48'h00_80_00_00_00_00, 0, "R3 byte1 miss");
        check(ref_accept(sta ^ 48'h1) == 1'b0, "R3 model", 0, 0);

        // R4
        wr(3'd0, 32'h0000_0008);
        frame_check(48'hFFFF_FFFF_FFFF, 0, "R4 broadcast blocked");
        check(acc_seen == 1'b0, "R4 blocked value", int'(acc_seen), 0);
        // R9 unused mode bits
        wr(3'd0, 32'hFFFF_FFD7);
        frame_check(48'hFFFF_FFFF_FFFF, 0, "R9 unused bits broadcast");
        frame_check(48'h04_11_22_33_44_55, 0, "R9 unused bits unicast miss");
        wr(3'd0, 32'h0);

        // R5 single bin in each word
        for (int t = 0; t < 2; t++) begin
            do begin
                mc = {$urandom, $urandom};
                mc[40] = 1'b1;
            end while (ref_idx(mc)[5] != t[0]);
            ix = ref_idx(mc);
            wr(3'd3, 32'h0); wr(3'd4, 32'h0);
            wr(ix[5] ? 3'd4 : 3'd3, 32'h1 << ix[4:0]);
            frame_check(mc, 0, "R5 single bin hit");
            check(acc_seen == 1'b1, "R5 bin hit value", int'(acc_seen), 1);
            wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
            wr(ix[5] ? 3'd4 : 3'd3, ~(32'h1 << ix[4:0]));
            frame_check(mc, 0, "R5 single bin clear");
            check(acc_seen == 1'b0, "R5 bin clear value", int'(acc_seen), 0);
        end

        // R6
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
        for (int t = 0; t < 8; t++) begin
            mc = {$urandom, $urandom}; mc[40] = 1'b1;
            frame_check(mc, 1, "R6 all bins");
        end

        // R7
        wr(3'd3, 32'h0); wr(3'd4, 32'h0);
        wr(3'd0, 32'h0000_0028);
        frame_check(48'hFFFF_FFFF_FFFF, 0, "R7 promisc broadcast");
        frame_check(48'h01_00_5E_00_00_01, 0, "R7 promisc multicast");
        frame_check(48'h00_DE_AD_BE_EF_00, 0, "R7 promisc unicast");
        wr(3'd0, 32'h0);

        // R8 restart after partial frame
        ndone = 0;
        start_pulse();
        send_bytes(48'h02_1A_2B_00_00_00, 3, 0);
        tick();
        check(ndone == 0, "R8 partial no done", ndone, 0);
        frame_check(sta, 0, "R8 restart hits station");
        // R8 stray bytes after verdict, R10 hold
        ndone = 0;
        send_bytes(sta, 6, 0);
        tick(); tick();
        check(ndone == 0, "R8 stray bytes no done", ndone, 0);
        check(match_accept == 1'b1, "R10 verdict held", int'(match_accept), 1);
        // R10 frame start clears
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        check(match_accept == 1'b0, "R10 cleared by frame start", int'(match_accept), 0);
        // R8 byte alongside frame start is dropped
        ndone = 0;
        frame_start = 1'b1; rx_valid = 1'b1; rx_byte = 8'hEE;
        tick();
        frame_start = 1'b0;
        send_bytes(sta, 6, 0);
        tick(); tick();
        check(ndone == 1 && acc_seen == 1'b1, "R8 byte with start dropped", ndone, 1);

        // random mix
        for (int f = 0; f < 400; f++) begin
            logic [47:0] a;
            int kind;
            if (f % 25 == 0) begin
                wr(3'd0, {$urandom} & 32'hFFFF_FFDF | (($urandom_range(0, 7) == 0) ? 32'h20 : 32'h0));
                wr(3'd3, ($urandom_range(0, 5) == 0) ? 32'hFFFF_FFFF : $urandom);
                wr(3'd4, $urandom);
                wr(3'd1, $urandom);
                wr(3'd2, {$urandom} & 32'hFFFF_FEFF);
            end
            kind = $urandom_range(0, 9);
            a = {$urandom, $urandom};
            if (kind < 3) a = {m_hi[15:0], m_lo};
            else if (kind == 3) a = 48'hFFFF_FFFF_FFFF;
            else if (kind < 7) a[40] = 1'b1;
            else a[40] = 1'b0;
            frame_check(a, 2, "R2 R3 R4 R5 R7 random frame");
        end

        report_end();
    end

endmodule